// File: doc/BRIEF.md
# I2C stuck-bus fault generator

This block is an open-drain agent that shares an I2C bus with a master under test and puts the bus into faulty states on command, so that the master's error detection and bus recovery can be tested. It has a pull-down output for each line, where 1 pulls the line low and 0 lets it float. It samples both wires through two-stage synchronizers and reports their levels.

A one-cycle command port selects the action. Either line can be forced low or let go. Two further commands run a deliberately stalled transfer to a 7-bit target. The block sends START and the address byte, and in write mode it also sends one zero data byte. It then gives up inside the acknowledge slot with SCL left high. A target that acknowledged therefore keeps holding SDA low.

A release command lets both lines float without generating STOP, so freeing the bus is left to the master under test. A programmable half-period sets the SCL rate of the stalled transfer.

Top module: `i2c_fault_gen`

## Requirements
- R1: Command code 1 makes `scl_pd` 1 and code 2 makes it 0. `scl_level` shows the sampled SCL wire, two clocks after that wire changes.
- R2: Command code 3 makes `sda_pd` 1 and code 4 makes it 0. `sda_level` shows the sampled SDA wire, two clocks after that wire changes.
- R3: Once forced by code 3, SDA stays pulled low for any length of time until code 4 or code 7 is accepted. There is no timeout.
- R4: Code 5 (read stall) pulls SDA low while SCL is high (START). It then clocks out the byte {address, 1} MSB first and stops in the acknowledge slot that follows.
- R5: Code 6 (write stall) sends START and then {address, 0}. It gives a full clock to the first acknowledge slot, sends 0x00, and stops in the second acknowledge slot.
- R6: At the stall point, `stalled` is 1 and both `scl_pd` and `sda_pd` are 0, so SCL reads high and SDA reads whatever the target drives.
- R7: Every command is ignored while `busy` is 1. A stall command is also ignored while `stalled` is 1 or while either line is forced.
- R8: `busy` rises in the cycle after a stall command is accepted. It stays 1 until the stall point and then falls, in the same cycle that `stalled` rises.
- R9: During a stalled transfer, each SCL low phase and each SCL high phase lasts max(`div_half`, 2) clocks. `sda_pd` changes only while SCL is pulled low, except at START.
- R10: Code 7 ends a stall and clears both forces. No STOP is sent: `sda_pd` stays 0 and a target that is still holding SDA keeps it low.
- R11: `ack_seen` holds the inverted SDA level sampled at the end of the final SCL high phase before the stall. It is cleared when a stall command is accepted.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cmd_valid | input | 1 | Command strobe, one cycle |
| cmd_op | input | 3 | 0 none, 1 SCL low, 2 SCL free, 3 SDA low, 4 SDA free, 5 read stall, 6 write stall, 7 free all |
| cmd_addr | input | 7 | Target address for stall commands |
| div_half | input | DIVW | SCL half-period in clocks (values below 2 act as 2) |
| scl_in | input | 1 | Sampled SCL wire |
| sda_in | input | 1 | Sampled SDA wire |
| scl_pd | output | 1 | Pull SCL low when 1 |
| sda_pd | output | 1 | Pull SDA low when 1 |
| scl_level | output | 1 | Synchronized SCL level |
| sda_level | output | 1 | Synchronized SDA level |
| busy | output | 1 | Stalled transfer in progress |
| stalled | output | 1 | Parked in the acknowledge slot |
| ack_seen | output | 1 | A target drove the final acknowledge slot low |

## Verification
The hardest state to reach from the ports is the stall with a target still holding SDA low after the block has let go of both lines, because it needs a device on the bus that decodes the address and acknowledges. The bench therefore wires both lines as wired-AND nets and adds an event-driven target model. This model detects START, shifts in bits on SCL rising edges and acknowledges a chosen address. Commands are also injected while a transfer is running and while the block is parked, to show that they are ignored.

// File: rtl/i2cfg_pkg.sv
package i2cfg_pkg;

  localparam int ADDR_W   = 7;
  localparam int BYTE_W   = 8;
  // clock slots per stall kind: bytes plus acknowledge slots
  localparam int SLOTS_RD = BYTE_W + 1;
  localparam int SLOTS_WR = 2 * (BYTE_W + 1);

  typedef enum logic [2:0] {
    OP_NONE     = 3'd0,
    OP_SCL_LOW  = 3'd1,
    OP_SCL_FREE = 3'd2,
    OP_SDA_LOW  = 3'd3,
    OP_SDA_FREE = 3'd4,
    OP_STALL_RD = 3'd5,
    OP_STALL_WR = 3'd6,
    OP_FREE_ALL = 3'd7
  } op_e;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_START,
    ST_LOW,
    ST_HIGH,
    ST_STALL
  } seq_e;

endpackage

// File: rtl/i2cfg_sync.sv
module i2cfg_sync #(
  parameter int W = 2
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);

  for (genvar i = 0; i < W; i++) begin : g_bit
    logic s1_q, s2_q;
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        s1_q <= 1'b1;
        s2_q <= 1'b1;
      end else begin
        s1_q <= d[i];
        s2_q <= s1_q;
      end
    end
    assign q[i] = s2_q;
  end

endmodule

// File: rtl/i2cfg_halfper.sv
module i2cfg_halfper #(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         run,
  input  logic [W-1:0] limit,
  output logic         done,
  output logic         first
);

  logic [W-1:0] cnt_q, cnt_d, lim;

  assign lim   = (limit < W'(2)) ? W'(2) : limit;
  assign done  = run && (cnt_q >= lim - W'(1));
  assign first = run && (cnt_q == '0);

  always_comb begin
    if (!run || done) cnt_d = '0;
    else              cnt_d = cnt_q + W'(1);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt_q <= '0;
    else        cnt_q <= cnt_d;
  end

endmodule

// File: rtl/i2cfg_seq.sv
module i2cfg_seq
  import i2cfg_pkg::*;
#(
  parameter int DIVW = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start,
  input  logic              wr,
  input  logic [ADDR_W-1:0] addr,
  input  logic              free,
  input  logic [DIVW-1:0]   div_half,
  input  logic              sda_s,
  output logic              busy,
  output logic              stalled,
  output logic              ack_seen,
  output logic              scl_drv,
  output logic              sda_drv
);

  localparam int KW = $clog2(SLOTS_WR);

  seq_e               st_q, st_d;
  logic [KW-1:0]      k_q, k_d, last;
  logic [BYTE_W-1:0]  abyte_q, abyte_d;
  logic               wr_q, wr_d;
  logic               scl_q, scl_d;
  logic               sda_q, sda_d;
  logic               ack_q, ack_d;
  logic               run, done, first, slot_bit;
  logic [2:0]         bit_idx;

  assign run     = (st_q == ST_START) || (st_q == ST_LOW) || (st_q == ST_HIGH);
  assign busy    = run;
  assign stalled = (st_q == ST_STALL);
  assign scl_drv = scl_q;
  assign sda_drv = sda_q;
  assign ack_seen = ack_q;

  i2cfg_halfper #(.W(DIVW)) u_hp (
    .clk   (clk),
    .rst_n (rst_n),
    .run   (run),
    .limit (div_half),
    .done  (done),
    .first (first)
  );

  assign last    = wr_q ? KW'(SLOTS_WR - 1) : KW'(SLOTS_RD - 1);
  assign bit_idx = ~k_q[2:0];

  // value to put on SDA for clock slot k (1 = float)
  always_comb begin
    if (k_q < KW'(BYTE_W))                      slot_bit = abyte_q[bit_idx];
    else if (k_q == KW'(BYTE_W) || k_q == last) slot_bit = 1'b1;
    else                                        slot_bit = 1'b0;
  end

  always_comb begin
    st_d    = st_q;
    k_d     = k_q;
    abyte_d = abyte_q;
    wr_d    = wr_q;
    scl_d   = scl_q;
    sda_d   = sda_q;
    ack_d   = ack_q;
    case (st_q)
      ST_IDLE: begin
        if (start) begin
          st_d    = ST_START;
          abyte_d = {addr, ~wr};
          wr_d    = wr;
          k_d     = '0;
          scl_d   = 1'b0;
          sda_d   = 1'b1;
          ack_d   = 1'b0;
        end
      end
      ST_START: begin
        if (done) begin
          st_d  = ST_LOW;
          scl_d = 1'b1;
        end
      end
      ST_LOW: begin
        if (first) sda_d = ~slot_bit;
        if (done) begin
          st_d  = ST_HIGH;
          scl_d = 1'b0;
        end
      end
      ST_HIGH: begin
        if (done) begin
          if (k_q == last) begin
            st_d  = ST_STALL;
            ack_d = ~sda_s;
          end else begin
            st_d  = ST_LOW;
            k_d   = k_q + KW'(1);
            scl_d = 1'b1;
          end
        end
      end
      ST_STALL: begin
        if (free) st_d = ST_IDLE;
      end
      default: st_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q    <= ST_IDLE;
      k_q     <= '0;
      abyte_q <= '0;
      wr_q    <= 1'b0;
      scl_q   <= 1'b0;
      sda_q   <= 1'b0;
      ack_q   <= 1'b0;
    end else begin
      st_q    <= st_d;
      k_q     <= k_d;
      abyte_q <= abyte_d;
      wr_q    <= wr_d;
      scl_q   <= scl_d;
      sda_q   <= sda_d;
      ack_q   <= ack_d;
    end
  end

  AST_SDA_MOVES_IN_LOW: assert property (@(posedge clk) disable iff (!rst_n)
    (sda_q != $past(sda_q)) && ($past(st_q) != ST_IDLE) |-> scl_q && $past(scl_q)); // R9

  AST_BUSY_ENDS_IN_STALL: assert property (@(posedge clk) disable iff (!rst_n)
    busy |=> busy || stalled); // R8

endmodule

// File: rtl/i2c_fault_gen.sv
module i2c_fault_gen
  import i2cfg_pkg::*;
#(
  parameter int DIVW = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cmd_valid,
  input  logic [2:0]        cmd_op,
  input  logic [ADDR_W-1:0] cmd_addr,
  input  logic [DIVW-1:0]   div_half,
  input  logic              scl_in,
  input  logic              sda_in,
  output logic              scl_pd,
  output logic              sda_pd,
  output logic              scl_level,
  output logic              sda_level,
  output logic              busy,
  output logic              stalled,
  output logic              ack_seen
);

  op_e  op;
  logic scl_s, sda_s;
  logic accept, forced, start_go, free_go;
  logic scl_force_q, scl_force_d, sda_force_q, sda_force_d;
  logic scl_drv, sda_drv;

  i2cfg_sync #(.W(2)) u_sync (
    .clk   (clk),
    .rst_n (rst_n),
    .d     ({scl_in, sda_in}),
    .q     ({scl_s, sda_s})
  );

  assign op       = op_e'(cmd_op);
  assign accept   = cmd_valid && !busy;
  assign forced   = scl_force_q || sda_force_q;
  assign start_go = accept && !stalled && !forced &&
                    ((op == OP_STALL_RD) || (op == OP_STALL_WR));
  assign free_go  = accept && (op == OP_FREE_ALL);

  always_comb begin
    scl_force_d = scl_force_q;
    sda_force_d = sda_force_q;
    case (op)
      OP_SCL_LOW:  scl_force_d = 1'b1;
      OP_SCL_FREE: scl_force_d = 1'b0;
      OP_SDA_LOW:  sda_force_d = 1'b1;
      OP_SDA_FREE: sda_force_d = 1'b0;
      OP_FREE_ALL: begin
        scl_force_d = 1'b0;
        sda_force_d = 1'b0;
      end
      default: ;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      scl_force_q <= 1'b0;
      sda_force_q <= 1'b0;
    end else if (accept) begin
      scl_force_q <= scl_force_d;
      sda_force_q <= sda_force_d;
    end
  end

  i2cfg_seq #(.DIVW(DIVW)) u_seq (
    .clk      (clk),
    .rst_n    (rst_n),
    .start    (start_go),
    .wr       (op == OP_STALL_WR),
    .addr     (cmd_addr),
    .free     (free_go),
    .div_half (div_half),
    .sda_s    (sda_s),
    .busy     (busy),
    .stalled  (stalled),
    .ack_seen (ack_seen),
    .scl_drv  (scl_drv),
    .sda_drv  (sda_drv)
  );

  assign scl_pd    = scl_force_q | scl_drv;
  assign sda_pd    = sda_force_q | sda_drv;
  assign scl_level = scl_s;
  assign sda_level = sda_s;

  AST_BUSY_IGNORES_CMD: assert property (@(posedge clk) disable iff (!rst_n)
    busy && cmd_valid |=> (scl_force_q == $past(scl_force_q)) && (sda_force_q == $past(sda_force_q))); // R7

  AST_SDA_NO_TIMEOUT: assert property (@(posedge clk) disable iff (!rst_n)
    sda_force_q && !(accept && ((op == OP_SDA_FREE) || (op == OP_FREE_ALL))) |=> sda_force_q); // R3

  AST_STALL_LINES_FREE: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(stalled) |-> !scl_pd && !sda_pd); // R6

endmodule

// File: tb/sim_i2c_fault_gen.sv
module sim_i2c_fault_gen;
  import i2cfg_pkg::*;

  localparam int DIVW = 8;

  logic clk = 1'b0;
  logic rst_n;
  logic cmd_valid;
  logic [2:0] cmd_op;
  logic [6:0] cmd_addr;
  logic [DIVW-1:0] div_half;
  logic scl_pd, sda_pd, scl_level, sda_level, busy, stalled, ack_seen;
  logic scl_line, sda_line;
  logic tgt_low;

  always #4 clk = ~clk;

  assign scl_line = !scl_pd;
  assign sda_line = !(sda_pd | tgt_low);

  i2c_fault_gen #(.DIVW(DIVW)) u0 (
    .clk (clk), .rst_n (rst_n), .cmd_valid (cmd_valid), .cmd_op (cmd_op),
    .cmd_addr (cmd_addr), .div_half (div_half), .scl_in (scl_line),
    .sda_in (sda_line), .scl_pd (scl_pd), .sda_pd (sda_pd),
    .scl_level (scl_level), .sda_level (sda_level), .busy (busy),
    .stalled (stalled), .ack_seen (ack_seen)
  );

  int nchk = 0;
  int nfail = 0;
  int h_exp = 4;
  bit finished = 0;
  logic [7:0] exp_q[$];

  task automatic check(input string req, input int act, input int exp);
    nchk++;
    if (act != exp) begin
      nfail++;
      $display("FAIL %s: got %0d expected %0d", req, act, exp);
    end
  endtask

  // ---------------- target model (monitor side of the scoreboard) -------
  bit tgt_en = 0;
  logic [6:0] tgt_addr = 7'h3A;
  bit prev_scl = 1, prev_sda = 1, in_frame = 0, ack_pend = 0, addr_acked = 0;
  int bits = 0, ack_phase = 0, byte_idx = 0;
  logic [7:0] sh = 0;

  initial tgt_low = 1'b0;

  always @(scl_line or sda_line) begin
    if (tgt_en) begin
      if (prev_scl && scl_line && prev_sda && !sda_line) begin
        in_frame = 1; bits = 0; ack_phase = 0; byte_idx = 0; addr_acked = 0;
      end else if (in_frame && !prev_scl && scl_line) begin
        if (bits < 8) begin
          sh = {sh[6:0], sda_line};
          bits++;
          if (bits == 8) begin
            if (exp_q.size() == 0) check("R4/R5 unexpected byte", int'(sh), -1);
            else check("R4/R5 byte on bus", int'(sh), int'(exp_q.pop_front()));
            ack_pend = (byte_idx == 0) ? (sh[7:1] == tgt_addr) : addr_acked;
            if (byte_idx == 0) addr_acked = ack_pend;
            ack_phase = 1;
          end
        end
      end else if (in_frame && prev_scl && !scl_line) begin
        if (ack_phase == 1) begin
          tgt_low = ack_pend;
          ack_phase = 2;
        end else if (ack_phase == 2) begin
          tgt_low = 1'b0;
          ack_phase = 0;
          bits = 0;
          byte_idx++;
        end
      end
    end
    prev_scl = scl_line;
    prev_sda = sda_line;
  end

  task automatic tgt_reset();
    tgt_en = 0; in_frame = 0; tgt_low = 1'b0; ack_phase = 0; bits = 0;
  endtask

  // ---------------- phase timing and SDA discipline monitor (R9) --------
  logic prev_pd = 0, prev_sdapd = 0, prev_busy = 0;
  int run_len = 0;
  bit run_valid = 0;

  always @(negedge clk) begin
    if (rst_n) begin
      if (busy && scl_pd != prev_pd) begin
        if (run_valid) check("R9 SCL phase length", run_len, h_exp);
        run_valid = 1;
        run_len = 1;
      end else run_len++;
      if (!busy) run_valid = 0;
      if (busy && prev_busy && sda_pd != prev_sdapd)
        check("R9 SDA moves only with SCL low", int'(scl_pd), 1);
      prev_pd = scl_pd;
      prev_sdapd = sda_pd;
      prev_busy = busy;
    end
  end

  // ---------------- driver ----------------------------------------------
  task automatic send(input op_e op, input logic [6:0] a);
    @(negedge clk);
    cmd_valid = 1'b1;
    cmd_op    = op;
    cmd_addr  = a;
    @(negedge clk);
    cmd_valid = 1'b0;
    cmd_op    = OP_NONE;
  endtask

  task automatic run_stall(input bit wr, input logic [6:0] a, input bit exp_ack);
    tgt_en = 1;
    exp_q.push_back({a, ~wr});
    if (wr) exp_q.push_back(8'h00);
    send(wr ? OP_STALL_WR : OP_STALL_RD, a);
    check("R8 busy after accept", int'(busy), 1);
    check("R11 ack_seen cleared at start", int'(ack_seen), 0);
    send(OP_SDA_LOW, 7'h00);          // must be ignored (R7)
    for (int i = 0; i < 4000; i++) begin
      if (stalled) break;
      @(negedge clk);
    end
    check("R8 reached stall", int'(stalled), 1);
    check("R8 busy low at stall", int'(busy), 0);
    check("R6 scl_pd at stall", int'(scl_pd), 0);
    check("R6 sda_pd at stall (R7 force ignored)", int'(sda_pd), 0);
    repeat (3) @(negedge clk);
    check("R6 SCL reads high", int'(scl_level), 1);
    check("R6 SDA reads target", int'(sda_level), exp_ack ? 0 : 1);
    check("R11 ack_seen", int'(ack_seen), int'(exp_ack));
    check("R4/R5 all bytes seen", exp_q.size(), 0);
    send(OP_STALL_WR, a);             // ignored while stalled (R7)
    check("R7 no restart while stalled", int'(busy), 0);
    check("R7 still stalled", int'(stalled), 1);
    send(OP_FREE_ALL, 7'h00);
    check("R10 stall ended", int'(stalled), 0);
    check("R10 scl free", int'(scl_pd), 0);
    check("R10 sda free, no STOP", int'(sda_pd), 0);
    repeat (3) @(negedge clk);
    check("R10 target still holds SDA", int'(sda_level), exp_ack ? 0 : 1);
    tgt_reset();
    repeat (3) @(negedge clk);
  endtask

  task automatic finish_run();
    if (!finished) begin
      finished = 1;
      $display("== %0d vectors applied, %0d miscompares ==", nchk, nfail);
      $finish;
    end
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    nfail++;
    nchk++;
    $display("FAIL watchdog: got %0d expected %0d", 1, 0);
    finish_run();
  end

  initial begin
    rst_n = 1'b0; cmd_valid = 1'b0; cmd_op = OP_NONE; cmd_addr = '0;
    div_half = 8'd4; h_exp = 4;
    repeat (5) @(negedge clk);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
    check("R8 reset busy", int'(busy), 0);
    check("R8 reset stalled", int'(stalled), 0);
    check("R1 reset scl_pd", int'(scl_pd), 0);
    check("R2 reset sda_pd", int'(sda_pd), 0);
    check("R11 reset ack_seen", int'(ack_seen), 0);

    // R1
    send(OP_SCL_LOW, 7'h00);
    check("R1 scl forced", int'(scl_pd), 1);
    repeat (2) @(negedge clk);
    check("R1 scl_level low", int'(scl_level), 0);
    send(OP_SCL_FREE, 7'h00);
    check("R1 scl released", int'(scl_pd), 0);
    repeat (2) @(negedge clk);
    check("R1 scl_level high", int'(scl_level), 1);

    // R2, R3
    send(OP_SDA_LOW, 7'h00);
    check("R2 sda forced", int'(sda_pd), 1);
    repeat (2) @(negedge clk);
    check("R2 sda_level low", int'(sda_level), 0);
    repeat (3000) @(negedge clk);
    check("R3 sda still forced", int'(sda_pd), 1);
    check("R3 sda still low", int'(sda_level), 0);
    send(OP_SDA_FREE, 7'h00);
    repeat (2) @(negedge clk);
    check("R2 sda_level high", int'(sda_level), 1);

    // R7: stall refused while a line is forced; R10 clears the force
    send(OP_SCL_LOW, 7'h00);
    send(OP_STALL_RD, 7'h3A);
    check("R7 stall refused under force", int'(busy), 0);
    check("R7 no stall under force", int'(stalled), 0);
    send(OP_FREE_ALL, 7'h00);
    check("R10 force cleared", int'(scl_pd), 0);
    repeat (3) @(negedge clk);

    // R4 read stall, acknowledging target
    run_stall(1'b0, 7'h3A, 1'b1);

    // R5 write stall, longer half-period
    div_half = 8'd7; h_exp = 7;
    run_stall(1'b1, 7'h3A, 1'b1);

    // R11 absent target, R9 minimum half-period clamp
    div_half = 8'd1; h_exp = 2;
    run_stall(1'b0, 7'h11, 1'b0);

    check("R4 scoreboard drained", exp_q.size(), 0);
    finish_run();
  end

endmodule